// File: doc/BRIEF.md
# Dual-Port Memory with Hardware Semaphores

This block is a byte-wide memory with two fully independent access ports, left and right. Each port has its own address, write data, read data, and active-low controls: select, write strobe, output enable and semaphore select. Either port can read or write any word. Both ports can work in the same clock cycle, including on the same word. A small bank of ownership flags sits next to the array. Two agents use these flags to agree on who holds a shared resource. A port claims a flag by writing 0 and gives it back by writing 1. A claim that cannot be granted yet is remembered and is granted when the flag is released.

All controls are sampled on the rising clock edge. Read data comes out of a register, so it appears in the cycle after the request, together with a drive-enable bit that a pad ring or bus mux can use in place of a tri-state buffer.

When both ports hit the same word in one cycle and at least one of them writes, the block has an arbiter. It can own that arbitration itself (master role), or it can take busy indications from a partner device so that several devices can be cascaded to build wider words (slave role). The full-size part uses 14 address bits (16K words). The address width is a parameter; it defaults to 10 so that the default build stays small.

Top module: `dpr_semram`

## Requirements
- R1: A port with select low, write strobe low and semaphore select high stores its write data at its address. A port with select low, write strobe high, output enable low and semaphore select high returns the stored word on its read data in the next cycle, with its drive enable at 1.
- R2: A port that is deselected (select high and semaphore select high), or that reads with output enable high, shows drive enable 0 and read data 0 in the next cycle.
- R3: Both ports reading the same word in the same cycle both receive the stored value.
- R4: A semaphore access (select high, semaphore select low) chooses one of 8 flags by address bits [2:0]. A write uses only data bit 0. A read with output enable low returns 8'h00 when the reading port owns the flag and 8'hFF otherwise.
- R5: Writing 0 to a flag grants it to the writer when the other port does not own it. Otherwise the request is recorded as pending and the writer keeps reading 8'hFF.
- R6: Writing 1 releases a flag that the writer owns. A pending request from the other port is then granted, and it is visible from the next cycle. Writing 1 to a flag the writer does not own withdraws the writer's own pending request.
- R7: When both ports request the same free flag in the same cycle, the left port gets it and the right port's request becomes pending.
- R8: Select low together with semaphore select low does nothing: no memory or flag change, and drive enable is 0 in the next cycle.
- R9: In the master role (ms_master=1), if both ports access the same word in one cycle and at least one writes, then r_busy_out is 1 in the next cycle, the right port's write is discarded, and a left write takes effect. l_busy_out stays 0.
- R10: In the slave role (ms_master=0), both busy outputs are 0. A high l_busy_in or r_busy_in discards that port's memory write, and reads are unaffected.
- R11: After reset, both drive enables and both busy outputs are 0 and every flag is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ms_master | input | 1 | 1: internal arbiter drives busy; 0: busy comes from the inputs |
| l_cs_n | input | 1 | Left memory select, active low |
| l_we_n | input | 1 | Left write strobe, active low (high = read) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data, registered |
| l_doe | output | 1 | Left read data valid / drive enable |
| l_busy_in | input | 1 | Left write block in the slave role |
| l_busy_out | output | 1 | Left busy from the arbiter |
| r_cs_n | input | 1 | Right memory select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data, registered |
| r_doe | output | 1 | Right read data valid / drive enable |
| r_busy_in | input | 1 | Right write block in the slave role |
| r_busy_out | output | 1 | Right busy from the arbiter |

## Verification
Some properties are checked on every cycle. A flag stays with its owner until the owner writes 1, and a release hands the flag to a pending requester. A collision in the master role raises right busy, and the slave role keeps both busy lines low. A deselected or illegal access never drives data. Other behaviour can only be shown by the bench's scenarios, because it needs memory contents across several cycles: a blocked or illegal write leaves the stored word unchanged, the left port's data wins a shared write, and both ports can read the same word in the same cycle. A randomized mix of access types on a few shared addresses, run against a bench-side model, covers both master and slave roles.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic mem_wr;
        logic mem_rd;
        logic sem_wr;
        logic sem_rd;
    } access_t;
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
    import dpr_pkg::*;
(
    input  logic    cs_n,
    input  logic    we_n,
    input  logic    oe_n,
    input  logic    sem_n,
    output access_t acc
);
    always_comb begin
        acc.mem_wr = !cs_n && !we_n && sem_n;
        acc.mem_rd = !cs_n && we_n && !oe_n && sem_n;
        acc.sem_wr = cs_n && !sem_n && !we_n;
        acc.sem_rd = cs_n && !sem_n && we_n && !oe_n;
    end
endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_q,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              b_shadowed;

    assign b_shadowed = a_we && (a_addr == b_addr);

    always_ff @(posedge clk) begin
        if (a_we) mem_q[a_addr] <= a_din;
        if (b_we && !b_shadowed) mem_q[b_addr] <= b_din;
    end

    assign a_q = mem_q[a_addr];
    assign b_q = mem_q[b_addr];
endmodule

// File: rtl/dpr_sem_bank.sv
module dpr_sem_bank
    import dpr_pkg::*;
#(
    parameter int SEM_N = 8,
    parameter int SEL_W = $clog2(SEM_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_wr,
    input  logic [SEL_W-1:0] l_sel,
    input  logic             l_bit,
    input  logic             r_wr,
    input  logic [SEL_W-1:0] r_sel,
    input  logic             r_bit,
    output logic             l_rd_bit,
    output logic             r_rd_bit
);
    typedef struct {
        owner_e           own [SEM_N];
        logic [SEM_N-1:0] lp;
        logic [SEM_N-1:0] rp;
    } sem_state_t;

    sem_state_t       st_d, st_q;
    logic [SEM_N-1:0] l_hit, r_hit;

    for (genvar g = 0; g < SEM_N; g++) begin : g_hit
        assign l_hit[g] = l_wr && (l_sel == SEL_W'(g));
        assign r_hit[g] = r_wr && (r_sel == SEL_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SEM_N; i++) begin
            if (l_hit[i] && !l_bit) begin
                if (st_d.own[i] != OWN_RIGHT) st_d.own[i] = OWN_LEFT;
                else                          st_d.lp[i]  = 1'b1;
            end
            if (l_hit[i] && l_bit) begin
                if (st_d.own[i] == OWN_LEFT) st_d.own[i] = OWN_NONE;
                st_d.lp[i] = 1'b0;
            end
            if (r_hit[i] && !r_bit) begin
                if (st_d.own[i] != OWN_LEFT) st_d.own[i] = OWN_RIGHT;
                else                         st_d.rp[i]  = 1'b1;
            end
            if (r_hit[i] && r_bit) begin
                if (st_d.own[i] == OWN_RIGHT) st_d.own[i] = OWN_NONE;
                st_d.rp[i] = 1'b0;
            end
            if (st_d.own[i] == OWN_NONE) begin
                if (st_d.lp[i]) begin
                    st_d.own[i] = OWN_LEFT;
                    st_d.lp[i]  = 1'b0;
                end else if (st_d.rp[i]) begin
                    st_d.own[i] = OWN_RIGHT;
                    st_d.rp[i]  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SEM_N; i++) st_q.own[i] <= OWN_NONE;
            st_q.lp <= '0;
            st_q.rp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_rd_bit = (st_q.own[l_sel] != OWN_LEFT);
    assign r_rd_bit = (st_q.own[r_sel] != OWN_RIGHT);

    for (genvar g = 0; g < SEM_N; g++) begin : g_chk
        // R6
        left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.own[g] == OWN_LEFT && !(l_hit[g] && l_bit)) |=> st_q.own[g] == OWN_LEFT);
        // R6
        right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.own[g] == OWN_RIGHT && !(r_hit[g] && r_bit)) |=> st_q.own[g] == OWN_RIGHT);
        // R6
        handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.own[g] == OWN_LEFT && l_hit[g] && l_bit && st_q.rp[g] && !r_hit[g])
            |=> st_q.own[g] == OWN_RIGHT);
    end
endmodule

// File: rtl/dpr_semram.sv
module dpr_semram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int SEM_N  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_master,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_sem_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_doe,
    input  logic              l_busy_in,
    output logic              l_busy_out,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_sem_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_doe,
    input  logic              r_busy_in,
    output logic              r_busy_out
);
    localparam int SEL_W = $clog2(SEM_N);

    typedef struct packed {
        logic [DATA_W-1:0] l_dout;
        logic              l_doe;
        logic [DATA_W-1:0] r_dout;
        logic              r_doe;
        logic              l_busy;
        logic              r_busy;
    } out_t;

    logic [1:0] cs_n_v, we_n_v, oe_n_v, sem_n_v;
    access_t    acc_v [2];

    assign cs_n_v  = {r_cs_n,  l_cs_n};
    assign we_n_v  = {r_we_n,  l_we_n};
    assign oe_n_v  = {r_oe_n,  l_oe_n};
    assign sem_n_v = {r_sem_n, l_sem_n};

    for (genvar g = 0; g < 2; g++) begin : g_dec
        dpr_port_decode u_dec (
            .cs_n  (cs_n_v[g]),
            .we_n  (we_n_v[g]),
            .oe_n  (oe_n_v[g]),
            .sem_n (sem_n_v[g]),
            .acc   (acc_v[g])
        );
    end

    logic clash, l_wr_ok, r_wr_ok;
    logic [DATA_W-1:0] l_arr_q, r_arr_q;
    logic l_sem_bit, r_sem_bit;

    assign clash = (acc_v[0].mem_wr || acc_v[0].mem_rd)
                && (acc_v[1].mem_wr || acc_v[1].mem_rd)
                && (l_addr == r_addr)
                && (acc_v[0].mem_wr || acc_v[1].mem_wr);

    assign l_wr_ok = acc_v[0].mem_wr && (ms_master || !l_busy_in);
    assign r_wr_ok = acc_v[1].mem_wr && (ms_master ? !clash : !r_busy_in);

    dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .a_we   (l_wr_ok),
        .a_addr (l_addr),
        .a_din  (l_din),
        .a_q    (l_arr_q),
        .b_we   (r_wr_ok),
        .b_addr (r_addr),
        .b_din  (r_din),
        .b_q    (r_arr_q)
    );

    dpr_sem_bank #(.SEM_N(SEM_N), .SEL_W(SEL_W)) u_sem (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_wr     (acc_v[0].sem_wr),
        .l_sel    (l_addr[SEL_W-1:0]),
        .l_bit    (l_din[0]),
        .r_wr     (acc_v[1].sem_wr),
        .r_sel    (r_addr[SEL_W-1:0]),
        .r_bit    (r_din[0]),
        .l_rd_bit (l_sem_bit),
        .r_rd_bit (r_sem_bit)
    );

    out_t out_d, out_q;

    always_comb begin
        out_d        = '0;
        out_d.l_doe  = acc_v[0].mem_rd || acc_v[0].sem_rd;
        out_d.r_doe  = acc_v[1].mem_rd || acc_v[1].sem_rd;
        if (acc_v[0].mem_rd)      out_d.l_dout = l_arr_q;
        else if (acc_v[0].sem_rd) out_d.l_dout = {DATA_W{l_sem_bit}};
        if (acc_v[1].mem_rd)      out_d.r_dout = r_arr_q;
        else if (acc_v[1].sem_rd) out_d.r_dout = {DATA_W{r_sem_bit}};
        out_d.l_busy = 1'b0;
        out_d.r_busy = ms_master && clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign l_dout     = out_q.l_dout;
    assign l_doe      = out_q.l_doe;
    assign r_dout     = out_q.r_dout;
    assign r_doe      = out_q.r_doe;
    assign l_busy_out = out_q.l_busy;
    assign r_busy_out = out_q.r_busy;

    // R9
    clash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_master && !r_cs_n && r_sem_n && !l_cs_n && l_sem_n && (l_addr == r_addr)
         && (!l_we_n || !r_we_n) && (!l_oe_n || !l_we_n) && (!r_oe_n || !r_we_n))
        |=> r_busy_out);
    // R10
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_master |=> (!l_busy_out && !r_busy_out));
    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && !l_sem_n) |=> !l_doe);
    // R2
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_cs_n && r_sem_n) |=> (!r_doe && r_dout == '0));
endmodule

// File: tb/sim_dpr_semram.sv
module sim_dpr_semram;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_master = 1'b1;
    logic l_cs_n = 1, l_we_n = 1, l_oe_n = 1, l_sem_n = 1, l_busy_in = 0;
    logic r_cs_n = 1, r_we_n = 1, r_oe_n = 1, r_sem_n = 1, r_busy_in = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [7:0] l_din = '0, r_din = '0;
    logic [7:0] l_dout, r_dout;
    logic l_doe, r_doe, l_busy_out, r_busy_out;

    always #10 clk = ~clk;

    dpr_semram u0 (
        .clk(clk), .rst_n(rst_n), .ms_master(ms_master),
        .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_sem_n(l_sem_n),
        .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_doe(l_doe),
        .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_sem_n(r_sem_n),
        .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_doe(r_doe),
        .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] mem_m [1024];
    bit         valid_m [1024];
    int         own_m [8];
    bit         lp_m [8], rp_m [8];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // {mem_wr, mem_rd, sem_wr, sem_rd}
    function automatic logic [3:0] dec(input logic cs, input logic we, input logic oe, input logic sm);
        return {!cs && !we && sm, !cs && we && !oe && sm, cs && !sm && !we, cs && !sm && we && !oe};
    endfunction

    task automatic sem_model(input bit lw, input int ls, input bit lb, input bit rw, input int rs, input bit rb);
        if (lw && !lb) begin if (own_m[ls] != 2) own_m[ls] = 1; else lp_m[ls] = 1; end
        if (lw && lb)  begin if (own_m[ls] == 1) own_m[ls] = 0; lp_m[ls] = 0; end
        if (rw && !rb) begin if (own_m[rs] != 1) own_m[rs] = 2; else rp_m[rs] = 1; end
        if (rw && rb)  begin if (own_m[rs] == 2) own_m[rs] = 0; rp_m[rs] = 0; end
        for (int i = 0; i < 8; i++)
            if (own_m[i] == 0) begin
                if (lp_m[i]) begin own_m[i] = 1; lp_m[i] = 0; end
                else if (rp_m[i]) begin own_m[i] = 2; rp_m[i] = 0; end
            end
    endtask

    task automatic step(input string tag);
        logic [3:0] la, ra;
        bit clash, lwok, rwok, ldv, rdv;
        logic [7:0] ld, rd;
        la = dec(l_cs_n, l_we_n, l_oe_n, l_sem_n);
        ra = dec(r_cs_n, r_we_n, r_oe_n, r_sem_n);
        ld = 8'h00; rd = 8'h00; ldv = 1; rdv = 1;
        if (la[2]) begin ld = mem_m[l_addr]; ldv = valid_m[l_addr]; end
        else if (la[0]) ld = (own_m[l_addr[2:0]] == 1) ? 8'h00 : 8'hFF;
        if (ra[2]) begin rd = mem_m[r_addr]; rdv = valid_m[r_addr]; end
        else if (ra[0]) rd = (own_m[r_addr[2:0]] == 2) ? 8'h00 : 8'hFF;
        clash = (la[3] || la[2]) && (ra[3] || ra[2]) && (l_addr == r_addr) && (la[3] || ra[3]);
        lwok = la[3] && (ms_master || !l_busy_in);
        rwok = ra[3] && (ms_master ? !clash : !r_busy_in);
        @(posedge clk);
        #3;
        chk(l_doe == (la[2] || la[0]), tag, "l_doe", l_doe, la[2] || la[0]);
        chk(r_doe == (ra[2] || ra[0]), tag, "r_doe", r_doe, ra[2] || ra[0]);
        if (ldv) chk(l_dout == ld, tag, "l_dout", l_dout, ld);
        if (rdv) chk(r_dout == rd, tag, "r_dout", r_dout, rd);
        chk(l_busy_out == 1'b0, tag, "l_busy_out", l_busy_out, 0);
        chk(r_busy_out == (ms_master && clash), tag, "r_busy_out", r_busy_out, ms_master && clash);
        if (lwok) begin mem_m[l_addr] = l_din; valid_m[l_addr] = 1; end
        if (rwok && !(lwok && l_addr == r_addr)) begin mem_m[r_addr] = r_din; valid_m[r_addr] = 1; end
        sem_model(la[1], int'(l_addr[2:0]), l_din[0], ra[1], int'(r_addr[2:0]), r_din[0]);
        @(negedge clk);
    endtask

    task automatic idle();
        l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_sem_n = 1; l_busy_in = 0;
        r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_sem_n = 1; r_busy_in = 0;
    endtask

    task automatic lmem(input bit wr, input int a, input int d);
        l_cs_n = 0; l_sem_n = 1; l_we_n = !wr; l_oe_n = wr; l_addr = AW'(a); l_din = 8'(d);
    endtask
    task automatic rmem(input bit wr, input int a, input int d);
        r_cs_n = 0; r_sem_n = 1; r_we_n = !wr; r_oe_n = wr; r_addr = AW'(a); r_din = 8'(d);
    endtask
    task automatic lsem(input bit wr, input int f, input bit b);
        l_cs_n = 1; l_sem_n = 0; l_we_n = !wr; l_oe_n = wr; l_addr = AW'(f); l_din = {7'h2A, b};
    endtask
    task automatic rsem(input bit wr, input int f, input bit b);
        r_cs_n = 1; r_sem_n = 0; r_we_n = !wr; r_oe_n = wr; r_addr = AW'(f); r_din = {7'h15, b};
    endtask

    task automatic rand_port(input bit left);
        int m = $urandom % 9;
        bit cs, we, oe, sm;
        int a = $urandom % 16;
        int d = $urandom % 256;
        case (m)
            0, 1, 2: begin cs = 0; we = 0; oe = $urandom % 2; sm = 1; end
            3, 4:    begin cs = 0; we = 1; oe = 0; sm = 1; end
            5:       begin cs = 1; we = 0; oe = 1; sm = 0; end
            6:       begin cs = 1; we = 1; oe = 0; sm = 0; end
            7:       begin cs = 0; we = $urandom % 2; oe = 0; sm = 0; end
            default: begin cs = $urandom % 2; we = 1; oe = 1; sm = 1; end
        endcase
        if (left) begin l_cs_n = cs; l_we_n = we; l_oe_n = oe; l_sem_n = sm; l_addr = AW'(a); l_din = 8'(d); end
        else      begin r_cs_n = cs; r_we_n = we; r_oe_n = oe; r_sem_n = sm; r_addr = AW'(a); r_din = 8'(d); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        for (int i = 0; i < 8; i++) begin own_m[i] = 0; lp_m[i] = 0; rp_m[i] = 0; end
        for (int i = 0; i < 1024; i++) begin valid_m[i] = 0; mem_m[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R11 reset state
        chk(!l_doe && !r_doe, "R11", "doe after reset", {l_doe, r_doe}, 0);
        chk(!l_busy_out && !r_busy_out, "R11", "busy after reset", {l_busy_out, r_busy_out}, 0);
        idle(); lsem(0, 3, 0); rsem(0, 6, 0); step("R11");

        // R1 fill, then read back
        for (int a = 0; a < 16; a++) begin idle(); lmem(1, a, 8'h30 + a * 7); step("R1"); end
        idle(); lmem(0, 4, 0); rmem(0, 11, 0); step("R1");
        // R3 same word read on both ports
        idle(); lmem(0, 5, 0); rmem(0, 5, 0); step("R3");
        // R2 output enable high and deselect
        idle(); lmem(0, 6, 0); l_oe_n = 1; step("R2");
        // R5 left claims flag 2, right requests it
        idle(); lsem(1, 2, 0); step("R5");
        idle(); lsem(0, 2, 0); rsem(0, 2, 0); step("R5");
        idle(); rsem(1, 2, 0); step("R5");
        idle(); lsem(0, 2, 0); rsem(0, 2, 0); step("R5");
        // R6 release hands over to pending right
        idle(); lsem(1, 2, 1); step("R6");
        idle(); lsem(0, 2, 0); rsem(0, 2, 0); step("R6");
        // R6 withdraw pending request
        idle(); lsem(1, 10, 0); step("R6");
        idle(); lsem(1, 2, 1); step("R6");
        idle(); rsem(1, 2, 1); step("R6");
        idle(); lsem(0, 2, 0); rsem(0, 2, 0); step("R6");
        // R7 simultaneous claim
        idle(); lsem(1, 5, 0); rsem(1, 5, 0); step("R7");
        idle(); lsem(0, 5, 0); rsem(0, 5, 0); step("R7");
        // R8 illegal combination
        idle(); l_cs_n = 0; l_sem_n = 0; l_we_n = 0; l_oe_n = 0; l_addr = 7; l_din = 8'hE1; step("R8");
        idle(); l_cs_n = 0; l_sem_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = 7; step("R8");
        idle(); lmem(0, 7, 0); lsem(0, 7, 0); lmem(0, 7, 0); step("R8");
        idle(); lsem(0, 7, 0); step("R8");
        // R9 collision in master role
        idle(); lmem(0, 9, 0); rmem(1, 9, 8'h5C); step("R9");
        idle(); rmem(0, 9, 0); step("R9");
        idle(); lmem(1, 8, 8'hA7); rmem(1, 8, 8'h7A); step("R9");
        idle(); lmem(0, 8, 0); rmem(0, 8, 0); step("R9");
        // R10 slave role
        ms_master = 0;
        idle(); rmem(1, 4, 8'h99); r_busy_in = 1; step("R10");
        idle(); lmem(1, 3, 8'h66); l_busy_in = 1; rmem(0, 3, 0); r_busy_in = 1; step("R10");
        idle(); lmem(0, 3, 0); rmem(0, 4, 0); step("R10");
        idle(); lmem(1, 12, 8'h12); rmem(1, 12, 8'h21); step("R10");
        idle(); lmem(0, 12, 0); step("R10");
        ms_master = 1;

        // random mix, master role then slave role (R1 R2 R4 R8 R9 R10)
        for (int n = 0; n < 4000; n++) begin
            idle();
            rand_port(1);
            rand_port(0);
            if (n >= 2500) begin
                ms_master = 0;
                l_busy_in = ($urandom % 4) == 0;
                r_busy_in = ($urandom % 4) == 0;
            end
            step(n >= 2500 ? "R10" : "R4");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule